// File: doc/BRIEF.md
# ADC conversion handshake controller

This block sits between a processor's I/O bus and a slow successive-approximation analog-to-digital converter. The converter has a chip select, a write strobe that starts a conversion, an active-low end-of-conversion line and an 8-bit result bus. A bus write to the data port starts a conversion. The controller holds chip select low and pulses the write strobe low for a set number of system clocks. It then waits for the conversion to finish, in one of two ways: a fixed minimum delay of at least 100 µs, or a falling edge on the end-of-conversion line.

When the conversion finishes, the controller captures the converter's result byte, sets a ready flag and raises an interrupt request. Software can poll a status port that shows whether a result is ready and whether a conversion is running. It can instead wait for the interrupt and then read the data port. That read returns the captured byte and clears both the ready flag and the interrupt. The completion mode is sampled when each conversion starts. The delay length is derived from the system clock frequency.

Top module: `adc_handshake_ctrl`

## Requirements
- R1: After reset, adc_cs_n and adc_wr_n are 1, irq is 0, io_rdata is 0x00, and a status read returns 0x00.
- R2: A write to the data port (address 0x40) while idle drives adc_cs_n and adc_wr_n low from the next clock edge. Both stay low for exactly STROBE_CYC cycles (default 2) and then return high. adc_wr_n is never low while adc_cs_n is high.
- R3: A write to the data port while a conversion is running has no effect. No new strobe is produced and the running conversion finishes at its original time.
- R4: In delay mode (cfg_delay_mode = 1 at start), ready and irq rise exactly STROBE_CYC + TIMEOUT_CYC cycles after the starting write edge. TIMEOUT_CYC is the smallest cycle count covering WAIT_US microseconds, which is 12500 at 125 MHz. In this mode, edges on adc_eoc_n are ignored.
- R5: In end-of-conversion mode (cfg_delay_mode = 0 at start), a falling edge on adc_eoc_n passes through a two-flop synchroniser and an edge detector. It completes the conversion on the third clock edge after the input goes low.
- R6: The value on adc_data at the completion edge is latched as the result. Later changes on adc_data do not alter what the data port returns.
- R7: A read of the status port (address 0x42) returns bit 0 = result ready and bit 1 = conversion busy, with all other bits 0. A status read does not clear the ready flag.
- R8: A read of the data port returns the latched result on io_rdata one cycle later, and clears both the ready flag and irq.
- R9: irq is high exactly when the ready flag is set.
- R10: Writes to any address other than 0x40 start nothing. Reads of addresses other than 0x40 and 0x42 return 0x00.
- R11: If a data-port read lands on the same edge as a completion, the read returns the previous result, and ready and irq are left set.
- R12: The completion mode is sampled at the start of a conversion. Changes to cfg_delay_mode during a conversion do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | ADDR_W (8) | I/O port address |
| io_wr | input | 1 | I/O write cycle, one clock |
| io_rd | input | 1 | I/O read cycle, one clock |
| io_rdata | output | DATA_W (8) | Registered read data, valid the cycle after io_rd |
| cfg_delay_mode | input | 1 | 1 = fixed-delay completion, 0 = end-of-conversion completion |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_wr_n | output | 1 | Converter start strobe, active low |
| adc_eoc_n | input | 1 | Converter end-of-conversion, active low, asynchronous |
| adc_data | input | DATA_W (8) | Converter result byte |
| irq | output | 1 | Interrupt request, high while a result is ready |

## Verification
A bus access is driven for one cycle and occupies one clock edge, and read data appears on io_rdata at that edge. A start edge s brings the strobe low after s and high again after s+2. In delay mode, the bench keeps a free-running edge counter, checks that irq is low at s+12501 and high at s+12502, and checks the strobe and irq on every cycle in between. In end-of-conversion mode, irq is checked low after the second edge and high after the third edge following the input's fall. All outputs are sampled on the falling clock edge.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STROBE = 2'd1,
        PH_CONV   = 2'd2
    } phase_e;

    localparam int STAT_READY_BIT = 0;
    localparam int STAT_BUSY_BIT  = 1;

    function automatic int cycles_for_us(input int clk_hz, input int us);
        return ((clk_hz / 1000) * us + 999) / 1000;
    endfunction

endpackage

// File: rtl/adc_hs_decode.sv
module adc_hs_decode #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h40,
    parameter logic [ADDR_W-1:0] STAT_PORT = 'h42
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              wr_data,
    output logic              rd_data,
    output logic              rd_stat,
    output logic              rd_other
);
    logic hit_data, hit_stat;

    always_comb begin
        hit_data = (io_addr == DATA_PORT);
        hit_stat = (io_addr == STAT_PORT);
        wr_data  = io_wr & hit_data;
        rd_data  = io_rd & hit_data;
        rd_stat  = io_rd & hit_stat;
        rd_other = io_rd & ~hit_data & ~hit_stat;
    end
endmodule

// File: rtl/adc_hs_sync.sv
module adc_hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic fall
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    assign chain_d[0] = din_n;

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            assign chain_d[g] = chain_q[g-1];
        end
    endgenerate

    always_comb begin
        prev_d = chain_q[STAGES-1];
        fall   = prev_q & ~chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end
endmodule

// File: rtl/adc_hs_timer.sv
module adc_hs_timer #(
    parameter int LIMIT = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(LIMIT - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
        expired = run & ~load & (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_handshake_ctrl.sv
module adc_handshake_ctrl
    import adc_hs_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] DATA_PORT  = 'h40,
    parameter logic [ADDR_W-1:0] STAT_PORT  = 'h42,
    parameter int                CLK_HZ     = 125_000_000,
    parameter int                WAIT_US    = 100,
    parameter int                STROBE_CYC = 2,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              cfg_delay_mode,
    output logic              adc_cs_n,
    output logic              adc_wr_n,
    input  logic              adc_eoc_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              irq
);
    localparam int TIMEOUT_CYC = cycles_for_us(CLK_HZ, WAIT_US);
    localparam int SC_W        = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

    typedef struct packed {
        phase_e            phase;
        logic [SC_W-1:0]   scnt;
        logic              mode_dly;
        logic              ready;
        logic              irq;
        logic [DATA_W-1:0] result;
        logic [DATA_W-1:0] rdata;
        logic              cs_n;
        logic              wr_n;
    } ctl_t;

    ctl_t st_d, st_q;

    logic dec_wr_data, dec_rd_data, dec_rd_stat, dec_rd_other;
    logic eoc_fall, tmr_expired, tmr_load, tmr_run;
    logic done, busy;
    logic [DATA_W-1:0] status;

    adc_hs_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_PORT (DATA_PORT),
        .STAT_PORT (STAT_PORT)
    ) u_decode (
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .wr_data  (dec_wr_data),
        .rd_data  (dec_rd_data),
        .rd_stat  (dec_rd_stat),
        .rd_other (dec_rd_other)
    );

    adc_hs_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din_n (adc_eoc_n),
        .fall  (eoc_fall)
    );

    adc_hs_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    always_comb begin
        st_d = st_q;

        busy     = (st_q.phase != PH_IDLE);
        tmr_load = (st_q.phase == PH_STROBE) && (st_q.scnt == '0);
        tmr_run  = (st_q.phase == PH_CONV) && st_q.mode_dly;
        done     = (st_q.phase == PH_CONV) &&
                   (st_q.mode_dly ? tmr_expired : eoc_fall);

        status                 = '0;
        status[STAT_READY_BIT] = st_q.ready;
        status[STAT_BUSY_BIT]  = busy;

        // read path: registered, one cycle after the strobe
        if (dec_rd_data) begin
            st_d.rdata = st_q.result;
            st_d.ready = 1'b0;
            st_d.irq   = 1'b0;
        end else if (dec_rd_stat) begin
            st_d.rdata = status;
        end else if (dec_rd_other) begin
            st_d.rdata = '0;
        end

        unique case (st_q.phase)
            PH_IDLE: begin
                if (dec_wr_data) begin
                    st_d.phase    = PH_STROBE;
                    st_d.scnt     = SC_W'(STROBE_CYC - 1);
                    st_d.mode_dly = cfg_delay_mode;
                    st_d.ready    = 1'b0;
                    st_d.irq      = 1'b0;
                    st_d.cs_n     = 1'b0;
                    st_d.wr_n     = 1'b0;
                end
            end
            PH_STROBE: begin
                if (st_q.scnt == '0) begin
                    st_d.phase = PH_CONV;
                    st_d.cs_n  = 1'b1;
                    st_d.wr_n  = 1'b1;
                end else begin
                    st_d.scnt = st_q.scnt - 1'b1;
                end
            end
            PH_CONV: begin
                if (done) begin
                    st_d.phase  = PH_IDLE;
                    st_d.result = adc_data;
                    st_d.ready  = 1'b1;
                    st_d.irq    = 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase:    PH_IDLE,
                      scnt:     '0,
                      mode_dly: 1'b0,
                      ready:    1'b0,
                      irq:      1'b0,
                      result:   '0,
                      rdata:    '0,
                      cs_n:     1'b1,
                      wr_n:     1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    logic              ready_w, idle_w, conv_w;
    logic [DATA_W-1:0] result_w;

    assign io_rdata = st_q.rdata;
    assign adc_cs_n = st_q.cs_n;
    assign adc_wr_n = st_q.wr_n;
    assign irq      = st_q.irq;
    assign ready_w  = st_q.ready;
    assign idle_w   = (st_q.phase == PH_IDLE);
    assign conv_w   = (st_q.phase == PH_CONV);
    assign result_w = st_q.result;

endmodule

// File: rtl/adc_hs_checker.sv
module adc_hs_checker #(
    parameter int DATA_W     = 8,
    parameter int STROBE_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_wr_data,
    input logic              dec_rd_data,
    input logic              dec_rd_stat,
    input logic              idle,
    input logic              conv,
    input logic              ready,
    input logic              irq,
    input logic [DATA_W-1:0] result,
    input logic [DATA_W-1:0] io_rdata,
    input logic              adc_cs_n,
    input logic              adc_wr_n
);
    int low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= 0;
        end else if (!adc_wr_n) begin
            low_cnt <= low_cnt + 1;
        end else begin
            low_cnt <= 0;
        end
    end

    assert_cs_with_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_wr_n |-> !adc_cs_n);

    assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= STROBE_CYC);

    assert_start_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_wr_n) |-> $past(dec_wr_data && idle));

    assert_ready_from_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(conv));

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> $stable(result));

    assert_status_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_rd_stat |=> (io_rdata[DATA_W-1:2] == '0));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_rd_data && !conv) |=> !ready);

    assert_irq_tracks_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ready);

endmodule

bind adc_handshake_ctrl adc_hs_checker #(
    .DATA_W     (DATA_W),
    .STROBE_CYC (STROBE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_wr_data (dec_wr_data),
    .dec_rd_data (dec_rd_data),
    .dec_rd_stat (dec_rd_stat),
    .idle        (idle_w),
    .conv        (conv_w),
    .ready       (ready_w),
    .irq         (irq),
    .result      (result_w),
    .io_rdata    (io_rdata),
    .adc_cs_n    (adc_cs_n),
    .adc_wr_n    (adc_wr_n)
);

// File: tb/tb_adc_handshake_ctrl.sv
`timescale 1ns/1ps
module tb_adc_handshake_ctrl;
    localparam int  S_CYC   = 2;
    localparam int  T_CYC   = ((125_000_000 / 1000) * 100 + 999) / 1000;
    localparam logic [7:0] A_DATA = 8'h40;
    localparam logic [7:0] A_STAT = 8'h42;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_rdata;
    logic       cfg_delay_mode = 1'b0;
    logic       adc_cs_n, adc_wr_n;
    logic       adc_eoc_n = 1'b1;
    logic [7:0] adc_data = 8'h00;
    logic       irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_handshake_ctrl dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .io_addr        (io_addr),
        .io_wr          (io_wr),
        .io_rd          (io_rd),
        .io_rdata       (io_rdata),
        .cfg_delay_mode (cfg_delay_mode),
        .adc_cs_n       (adc_cs_n),
        .adc_wr_n       (adc_wr_n),
        .adc_eoc_n      (adc_eoc_n),
        .adc_data       (adc_data),
        .irq            (irq)
    );

    function automatic logic [7:0] exp_status(input bit rdy, input bit bsy);
        return {6'b0, bsy, rdy};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a);
        io_addr = a; io_wr = 1'b1;
        tick();
        io_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        tick();
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        int s_cyc;
        void'($urandom(32'd1234));

        // R1: reset state
        repeat (3) tick();
        check("R1 cs_n", adc_cs_n, 1);
        check("R1 wr_n", adc_wr_n, 1);
        check("R1 irq", irq, 0);
        check("R1 rdata", io_rdata, 0);
        rst_n = 1'b1;
        tick();
        bus_read(A_STAT, rd);
        check("R1 status", rd, exp_status(0, 0));

        // directed end-of-conversion conversion
        cfg_delay_mode = 1'b0;
        adc_data = 8'hA5;
        bus_write(A_DATA);
        check("R2 wr_n low first", adc_wr_n, 0);
        check("R2 cs_n low first", adc_cs_n, 0);
        tick();
        check("R2 wr_n low second", adc_wr_n, 0);
        tick();
        check("R2 wr_n released", adc_wr_n, 1);
        check("R2 cs_n released", adc_cs_n, 1);
        bus_read(A_STAT, rd);
        check("R7 busy status", rd, exp_status(0, 1));
        adc_eoc_n = 1'b0;
        tick();
        tick();
        check("R5 not yet after 2 edges", irq, 0);
        tick();
        check("R5 done after 3 edges", irq, 1);
        check("R9 irq on completion", irq, 1);
        adc_data = 8'h3C;
        adc_eoc_n = 1'b1;
        bus_read(A_STAT, rd);
        check("R7 ready status", rd, exp_status(1, 0));
        bus_read(A_STAT, rd);
        check("R7 status read keeps ready", rd, exp_status(1, 0));
        bus_read(A_DATA, rd);
        check("R6 latched result", rd, 8'hA5);
        check("R8 irq cleared by data read", irq, 0);
        bus_read(A_STAT, rd);
        check("R8 ready cleared", rd, exp_status(0, 0));

        // R10: other addresses
        bus_write(8'h41);
        check("R10 no strobe on other write", adc_wr_n, 1);
        bus_read(A_STAT, rd);
        check("R10 not busy", rd, exp_status(0, 0));
        bus_read(A_DATA, rd);
        check("R6 result retained", rd, 8'hA5);
        bus_read(8'h43, rd);
        check("R10 other read zero", rd, 8'h00);

        // delay mode with mid-conversion mode change, eoc pulse and busy write
        cfg_delay_mode = 1'b1;
        adc_data = 8'h5A;
        bus_write(A_DATA);
        s_cyc = cyc;
        cfg_delay_mode = 1'b0;   // R12: must not matter
        tick(); tick();
        bus_write(A_DATA);       // R3: ignored while busy
        adc_eoc_n = 1'b0;        // R4: ignored in delay mode
        repeat (4) tick();
        adc_eoc_n = 1'b1;
        while (cyc < s_cyc + S_CYC + T_CYC - 1) begin
            if (adc_wr_n !== 1'b1 || irq !== 1'b0) begin
                check("R3 no restrobe during delay", adc_wr_n, 1);
                check("R12 no early completion", irq, 0);
            end
            tick();
        end
        check("R4 not ready one cycle early", irq, 0);
        check("R3 strobe idle during conversion", adc_wr_n, 1);
        tick();
        check("R4 ready at timeout", irq, 1);
        check("R12 delay mode held", irq, 1);
        bus_read(A_DATA, rd);
        check("R6 delay result", rd, 8'h5A);

        // R12: started in eoc mode, switched to delay mid-way
        cfg_delay_mode = 1'b0;
        adc_data = 8'hC3;
        bus_write(A_DATA);
        cfg_delay_mode = 1'b1;
        tick(); tick();
        adc_eoc_n = 1'b0;
        repeat (3) tick();
        check("R12 eoc mode held", irq, 1);
        adc_eoc_n = 1'b1;
        bus_read(A_DATA, rd);
        check("R12 result", rd, 8'hC3);
        cfg_delay_mode = 1'b0;

        // R11: data read on completion edge
        adc_data = 8'h77;
        bus_write(A_DATA);
        tick(); tick();
        adc_eoc_n = 1'b0;
        tick(); tick();
        bus_read(A_DATA, rd);
        check("R11 read returns previous", rd, 8'hC3);
        check("R11 irq kept", irq, 1);
        adc_eoc_n = 1'b1;
        bus_read(A_STAT, rd);
        check("R11 ready kept", rd, exp_status(1, 0));
        bus_read(A_DATA, rd);
        check("R11 new result", rd, 8'h77);

        // random end-of-conversion conversions
        for (int n = 0; n < 24; n++) begin
            logic [7:0] val;
            int wait_c;
            val = 8'($urandom_range(0, 255));
            wait_c = $urandom_range(2, 20);
            bus_write(A_DATA);
            tick(); tick();
            for (int k = 0; k < wait_c; k++) begin
                if ($urandom_range(0, 3) == 0) begin
                    bus_read(A_STAT, rd);
                    check("R7 random busy poll", rd, exp_status(0, 1));
                end else begin
                    if ($urandom_range(0, 1) == 0) bus_write(A_DATA);
                    else tick();
                    check("R3 random no restrobe", adc_wr_n, 1);
                end
            end
            adc_data = val;
            adc_eoc_n = 1'b0;
            repeat (3) tick();
            check("R5 random completion", irq, 1);
            adc_data = ~val;
            adc_eoc_n = 1'b1;
            bus_read(A_STAT, rd);
            check("R7 random ready", rd, exp_status(1, 0));
            bus_read(A_DATA, rd);
            check("R6 random result", rd, val);
            check("R8 random irq cleared", irq, 0);
        end

        finish_run();
    end
endmodule